// File: doc/BRIEF.md
# Prioritised Interrupt Status and Mask Unit

This unit gathers thirteen level-sensitive interrupt requests from peripherals into a 32-bit status register. A 32-bit enable mask register sits beside it. Each request owns one fixed status bit. The sources fall into three groups, and each group asks the processor for one fixed priority level with one autovector number. The unit turns the enabled pending bits into a registered level code and a registered vector number for the processor.

Software reaches both registers through a simple word-wide bus port. A bus write replaces the whole register, and a bus read returns it. A separate control strobe from the storage-controller block sets or clears the storage-DMA status bit directly. That strobe follows the DMA-enable bit written into the storage control register.

Request inputs are indexed as follows:
0 floppy, 1 keyboard, 2 power, 3 network receive, 4 network transmit, 5 storage, 6 clock, 7 serial, 8 network transmit DMA, 9 network receive DMA, 10 storage DMA, 11 sound, 12 serial DMA.

Top module: `irqPrioUnit`

## Requirements
- R1: A rising request sets its status bit. The bit positions are: floppy 7, keyboard 3, power 2, network receive 9, network transmit 10, storage 12, clock 5, serial 17, network transmit DMA 28, network receive DMA 27, storage DMA 26, sound 23, serial DMA 21. The bit is set on the clock edge at which the new request level is first sampled.
- R2: A falling request clears its status bit on the clock edge at which the new level is first sampled. A request held steady leaves its bit as it is.
- R3: Sources 0 to 6 request level 3 with vector 27. Source 7 requests level 5 with vector 29. Sources 8 to 12 request level 6 with vector 30.
- R4: When pending enabled bits belong to more than one group, the output carries the highest level and that level's vector.
- R5: A status bit counts as pending only if the mask bit at the same position is 1. When nothing is pending and enabled, `ipl` is 0 and `vector` is 0.
- R6: A bus write at offset 0x7000 replaces the whole status register. A bus write at offset 0x7800 replaces the whole mask register. Bus reads at those offsets return the registers. A write to any other offset changes nothing, and a read there returns 0.
- R7: A strobe on `ctlWe` sets status bit 26 when `ctlDmaEn` is 1 and clears it when `ctlDmaEn` is 0.
- R8: `ipl` and `vector` follow the status and mask registers one clock after those registers change.
- R9: When updates to the same bit meet in one cycle, a request edge beats the control strobe, and the control strobe beats a bus status write.
- R10: Status bits that no source owns never raise the level, even when they are set and enabled.
- R11: After reset, status, mask, `ipl` and `vector` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 13 | Level requests, indexed as above |
| busSel | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 16 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| ctlWe | input | 1 | Storage-control DMA-enable update strobe |
| ctlDmaEn | input | 1 | DMA-enable value carried by the strobe |
| ipl | output | 3 | Registered processor priority level |
| vector | output | 8 | Registered autovector number |

## Verification
The assertions assume that request inputs and bus strobes change only between clock edges. They also assume that a request is low or steady through reset, so a fall seen just after reset is ignored whenever a competing write hits the same bit. The bench drives every input on the falling clock edge and samples after the second rising edge that follows a change. Competing writes to one bit are applied only in the directed priority tests, so the assertions that exclude them stay meaningful.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;

  localparam int NUM_SRC     = 13;
  localparam int LVL_W       = 3;
  localparam int VEC_W       = 8;
  localparam int VEC_BASE    = 24;
  localparam int SCSI_DMA_SRC = 10;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic dmaSet;
    logic dmaClr;
    logic rdStatus;
    logic rdMask;
  } ctlStrobe_t;

  // Fixed status bit owned by each request source.
  function automatic int srcBit(int idx);
    case (idx)
      0:  return 7;
      1:  return 3;
      2:  return 2;
      3:  return 9;
      4:  return 10;
      5:  return 12;
      6:  return 5;
      7:  return 17;
      8:  return 28;
      9:  return 27;
      10: return 26;
      11: return 23;
      12: return 21;
      default: return -1;
    endcase
  endfunction

  // Priority group of each source.
  function automatic int srcLevel(int idx);
    if (idx < 7)       return 3;
    else if (idx == 7) return 5;
    else               return 6;
  endfunction

  // Sources that feed a given status bit.
  function automatic logic [NUM_SRC-1:0] srcSelMask(int bitPos);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (srcBit(s) == bitPos) m[s] = 1'b1;
    return m;
  endfunction

  // Status bits that belong to a given level.
  function automatic logic [31:0] levelMask(int lvl);
    logic [31:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (srcLevel(s) == lvl) m[srcBit(s)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqBusCtrl.sv
module irqBusCtrl
  import irqPrioPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ctlWe,
  input  logic              ctlDmaEn,
  output ctlStrobe_t        strb
);

  logic hitStatus;
  logic hitMask;

  assign hitStatus = (busAddr == STATUS_OFS);
  assign hitMask   = (busAddr == MASK_OFS);

  always_comb begin
    strb          = '0;
    strb.wrStatus = busSel && busWe && hitStatus;
    strb.wrMask   = busSel && busWe && hitMask;
    strb.rdStatus = busSel && !busWe && hitStatus;
    strb.rdMask   = busSel && !busWe && hitMask;
    strb.dmaSet   = ctlWe && ctlDmaEn;
    strb.dmaClr   = ctlWe && !ctlDmaEn;
  end

endmodule

// File: rtl/irqStatusPath.sv
module irqStatusPath
  import irqPrioPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] irqReq,
  output logic [DATA_W-1:0]  statusQ,
  output logic [DATA_W-1:0]  maskQ,
  output logic [DATA_W-1:0]  busRdata
);

  localparam int DMA_BIT = srcBit(SCSI_DMA_SRC);

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] riseSrc;
  logic [NUM_SRC-1:0] fallSrc;
  logic [DATA_W-1:0]  riseBits;
  logic [DATA_W-1:0]  fallBits;
  logic [DATA_W-1:0]  statusD;

  assign riseSrc = irqReq & ~reqPrev;
  assign fallSrc = ~irqReq & reqPrev;

  // Route source edges onto their status bits.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam logic [NUM_SRC-1:0] SRCS = srcSelMask(b);
    assign riseBits[b] = |(riseSrc & SRCS);
    assign fallBits[b] = |(fallSrc & SRCS);
  end

  // Lowest to highest precedence: bus write, control strobe, request edge.
  always_comb begin
    statusD = statusQ;
    if (strb.wrStatus) statusD = busWdata;
    if (strb.dmaSet)   statusD[DMA_BIT] = 1'b1;
    if (strb.dmaClr)   statusD[DMA_BIT] = 1'b0;
    statusD = (statusD & ~fallBits) | riseBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      reqPrev <= irqReq;
      statusQ <= statusD;
      if (strb.wrMask) maskQ <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdStatus)    busRdata = statusQ;
    else if (strb.rdMask) busRdata = maskQ;
  end

endmodule

// File: rtl/irqPrioEncode.sv
module irqPrioEncode
  import irqPrioPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] statusQ,
  input  logic [DATA_W-1:0] maskQ,
  output logic [LVL_W-1:0]  ipl,
  output logic [VEC_W-1:0]  vector
);

  localparam int NUM_LVL = 1 << LVL_W;

  logic [DATA_W-1:0]  pend;
  logic [NUM_LVL-1:0] lvlHit;
  logic [LVL_W-1:0]   lvlD;
  logic [VEC_W-1:0]   vecD;

  assign pend = statusQ & maskQ;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam logic [31:0] LMASK = levelMask(l);
    if (l == 0) begin : g_none
      assign lvlHit[l] = 1'b0;
    end else begin : g_some
      assign lvlHit[l] = |(pend & LMASK[DATA_W-1:0]);
    end
  end

  always_comb begin
    lvlD = '0;
    for (int l = 1; l < NUM_LVL; l++)
      if (lvlHit[l]) lvlD = LVL_W'(l);
    vecD = (lvlD == '0) ? '0 : VEC_W'(VEC_BASE) + VEC_W'(lvlD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipl    <= '0;
      vector <= '0;
    end else begin
      ipl    <= lvlD;
      vector <= vecD;
    end
  end

endmodule

// File: rtl/irqPrioUnit.sv
module irqPrioUnit
  import irqPrioPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               ctlWe,
  input  logic               ctlDmaEn,
  output logic [LVL_W-1:0]   ipl,
  output logic [VEC_W-1:0]   vector
);

  ctlStrobe_t        strb;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;

  irqBusCtrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) uCtrl (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .ctlWe(ctlWe), .ctlDmaEn(ctlDmaEn), .strb(strb)
  );

  irqStatusPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .irqReq(irqReq), .statusQ(statusQ), .maskQ(maskQ), .busRdata(busRdata)
  );

  irqPrioEncode #(.DATA_W(DATA_W)) uEnc (
    .clk(clk), .rstN(rstN), .statusQ(statusQ), .maskQ(maskQ),
    .ipl(ipl), .vector(vector)
  );

endmodule

// File: rtl/irqPrioUnit_chk.sv
module irqPrioUnit_chk
  import irqPrioPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               busSel,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               ctlWe,
  input logic               ctlDmaEn,
  input logic [LVL_W-1:0]   ipl,
  input logic [VEC_W-1:0]   vector,
  input logic [DATA_W-1:0]  statusQ,
  input logic [DATA_W-1:0]  maskQ
);

  localparam logic [31:0] L3 = levelMask(3);
  localparam logic [31:0] L5 = levelMask(5);
  localparam logic [31:0] L6 = levelMask(6);
  localparam int DMA_BIT = srcBit(SCSI_DMA_SRC);

  logic busStatusWr;
  logic [DATA_W-1:0] pend;
  assign busStatusWr = busSel && busWe && (busAddr == STATUS_OFS);
  assign pend = statusQ & maskQ;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int BP = srcBit(g);

    assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqReq[g]) |=> statusQ[BP]);

    assert_fall_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(irqReq[g]) && !busStatusWr && !(g == SCSI_DMA_SRC && ctlWe))
        |=> !statusQ[BP]);
  end

  assert_top_group_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(pend & L6[DATA_W-1:0])) |=> (ipl == 3'd6 && vector == 8'd30));

  assert_mid_group_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|(pend & L5[DATA_W-1:0])) && !(|(pend & L6[DATA_W-1:0])))
      |=> (ipl == 3'd5 && vector == 8'd29));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(|(pend & (L3 | L5 | L6))) |=> (ipl == '0 && vector == '0));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == MASK_OFS) |=> (maskQ == $past(busWdata)));

  assert_ctl_dma_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && !irqReq[SCSI_DMA_SRC] && $stable(irqReq[SCSI_DMA_SRC]))
      |=> (statusQ[DMA_BIT] == $past(ctlDmaEn)));

endmodule

bind irqPrioUnit irqPrioUnit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .ctlWe(ctlWe), .ctlDmaEn(ctlDmaEn),
  .ipl(ipl), .vector(vector), .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/irqPrioUnit_test.sv
module irqPrioUnit_test;

  localparam logic [15:0] ST = 16'h7000;
  localparam logic [15:0] MK = 16'h7800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] irqReq = '0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        ctlWe = 1'b0;
  logic        ctlDmaEn = 1'b0;
  logic [2:0]  ipl;
  logic [7:0]  vector;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  irqPrioUnit uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ctlWe(ctlWe), .ctlDmaEn(ctlDmaEn), .ipl(ipl), .vector(vector)
  );

  typedef struct packed {
    logic [12:0] req;
    logic [31:0] mask;
    logic [31:0] stat;
    logic [2:0]  lvl;
    logic [7:0]  vec;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{13'h0001, 32'hFFFFFFFF, 32'h00000080, 3'd3, 8'd27},
    '{13'h0080, 32'hFFFFFFFF, 32'h00020000, 3'd5, 8'd29},
    '{13'h0081, 32'hFFFFFFFF, 32'h00020080, 3'd5, 8'd29},
    '{13'h0181, 32'hFFFFFFFF, 32'h10020080, 3'd6, 8'd30},
    '{13'h0181, 32'h00000080, 32'h10020080, 3'd3, 8'd27},
    '{13'h0181, 32'h00020000, 32'h10020080, 3'd5, 8'd29},
    '{13'h0181, 32'h00000000, 32'h10020080, 3'd0, 8'd0},
    '{13'h1FFF, 32'hFFFFFFFF, 32'h1CA216AC, 3'd6, 8'd30},
    '{13'h007F, 32'hFFFFFFFF, 32'h000016AC, 3'd3, 8'd27},
    '{13'h0000, 32'hFFFFFFFF, 32'h00000000, 3'd0, 8'd0},
    '{13'h0040, 32'hFFFFFFDF, 32'h00000020, 3'd0, 8'd0},
    '{13'h0800, 32'h00800000, 32'h00800000, 3'd6, 8'd30}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    check("R11 ipl", {29'd0, ipl}, 32'd0);
    check("R11 vector", {24'd0, vector}, 32'd0);
    busRead(ST, rd); check("R11 status", rd, 32'd0);
    busRead(MK, rd); check("R11 mask", rd, 32'd0);

    // R1 R2 R3 R4 R5: table walk
    for (int i = 0; i < 12; i++) begin
      busWrite(MK, TABLE[i].mask);
      irqReq = TABLE[i].req;
      settle();
      check("R3/R4/R5 ipl", {29'd0, ipl}, {29'd0, TABLE[i].lvl});
      check("R3/R4/R5 vector", {24'd0, vector}, {24'd0, TABLE[i].vec});
      busRead(ST, rd); check("R1/R2 status", rd, TABLE[i].stat);
    end

    // R8: one-clock lag after a mask change (sound pending, level 6)
    busWrite(MK, 32'h0);
    check("R8 lag ipl", {29'd0, ipl}, 32'd6);
    @(negedge clk);
    check("R8 after ipl", {29'd0, ipl}, 32'd0);
    irqReq = '0;
    settle();

    // R6: bus write replaces status; level follows mapped bits
    busWrite(ST, 32'hDEADBEEF);
    busRead(ST, rd); check("R6 status readback", rd, 32'hDEADBEEF);
    busWrite(MK, 32'h00000004);
    @(negedge clk);
    check("R6 masked level", {29'd0, ipl}, 32'd3);
    busWrite(MK, 32'hFFFFFFFF);
    @(negedge clk);
    check("R6 full level", {29'd0, ipl}, 32'd6);

    // R6: other offsets ignored, read as 0
    busWrite(16'h7004, 32'h12345678);
    busRead(ST, rd); check("R6 status untouched", rd, 32'hDEADBEEF);
    busRead(MK, rd); check("R6 mask untouched", rd, 32'hFFFFFFFF);
    busRead(16'h7004, rd); check("R6 unmapped read", rd, 32'h0);

    // R10: unmapped status bits alone
    busWrite(ST, 32'h00000001);
    @(negedge clk);
    check("R10 ipl", {29'd0, ipl}, 32'd0);
    check("R10 vector", {24'd0, vector}, 32'd0);

    // R7: control strobe sets then clears bit 26
    busWrite(ST, 32'h0);
    ctlWe = 1'b1; ctlDmaEn = 1'b1;
    @(negedge clk); ctlWe = 1'b0;
    busRead(ST, rd); check("R7 set", rd, 32'h04000000);
    @(negedge clk);
    check("R7 level", {29'd0, ipl}, 32'd6);
    ctlWe = 1'b1; ctlDmaEn = 1'b0;
    @(negedge clk); ctlWe = 1'b0;
    busRead(ST, rd); check("R7 clear", rd, 32'h0);

    // R9: request edge beats bus write
    busSel = 1'b1; busWe = 1'b1; busAddr = ST; busWdata = 32'h0;
    irqReq = 13'h0001;
    @(negedge clk); busSel = 1'b0; busWe = 1'b0;
    busRead(ST, rd); check("R9 edge over bus", rd, 32'h00000080);

    // R9: control strobe beats bus write
    busSel = 1'b1; busWe = 1'b1; busAddr = ST; busWdata = 32'hFFFFFFFF;
    ctlWe = 1'b1; ctlDmaEn = 1'b0;
    @(negedge clk); busSel = 1'b0; busWe = 1'b0; ctlWe = 1'b0;
    busRead(ST, rd); check("R9 ctl over bus", rd, 32'hFBFFFFFF);

    // R9: request edge beats control strobe on bit 26
    irqReq = 13'h0401;
    ctlWe = 1'b1; ctlDmaEn = 1'b0;
    @(negedge clk); ctlWe = 1'b0;
    busRead(ST, rd); check("R9 edge over ctl", rd, 32'hFFFFFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule